// File: doc/BRIEF.md
# Link-Level Retransmission Controller

This block sits on the transmit side of one point-to-point link and makes delivery across that single hop reliable. Each packet offered on the input stream gets the next value of a 12-bit wrapping sequence counter. The packet goes out on the output stream with that number and a copy is kept in a local store. The far end answers with positive or negative acknowledgements that carry a sequence value. A positive answer frees the named packet and everything older. A negative answer, or a long silence from the far end, makes the block send the stored packets again, oldest first, each with the number it was first given.

A packet is one beat of `DATA_W` bits. While a retransmission is running, the output is fed from the store and the input stream is held off. The block does no checksum generation, does not encode the acknowledgement packets and does no framing. Those belong to neighbouring logic.

Top module: `dllr_replay_ctrl`

## Requirements
- R1: After reset the store is empty, `out_valid` is low while `in_valid` is low, and the first packet offered carries sequence 0.
- R2: New packets pass combinationally from `in_data` to `out_data`. They carry consecutive sequence numbers modulo 4096, so 4095 is followed by 0. A packet is taken when `in_valid`, `in_ready` and `out_ready` are all high.
- R3: At most `DEPTH` unacknowledged packets are held. When `DEPTH` are held, `in_ready` and `out_valid` stay low whatever `in_valid` does.
- R4: A positive acknowledgement (`ack_valid`=1, `ack_nak`=0) for a held sequence N releases N and every older held packet. Released packets are never sent again.
- R5: An acknowledgement of either kind whose sequence is not held is ignored. Held means the distance from the oldest held sequence, computed modulo 4096, is below the held count. An ignored acknowledgement releases nothing and starts no retransmission.
- R6: A negative acknowledgement (`ack_nak`=1) for a held sequence N releases the packets older than N. It then resends N up to the newest packet, in the original order, with the original sequence numbers and data.
- R7: While a retransmission is running, `in_ready` is low and no new packet is taken.
- R8: If packets are held and no acknowledgement makes progress for `TIMEOUT` cycles, all held packets are resent starting from the oldest.
- R9: The timeout counter restarts whenever an acknowledgement releases at least one packet, and it stays stopped while the store is empty.
- R10: A positive acknowledgement that arrives during a retransmission skips any released packets not yet resent. The retransmission ends once the newest held packet has gone out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New packet offered |
| in_data | input | DATA_W | New packet payload |
| in_ready | output | 1 | New packet may be taken this cycle |
| out_valid | output | 1 | Outgoing packet present |
| out_data | output | DATA_W | Outgoing packet payload |
| out_seq | output | 12 | Sequence number of the outgoing packet |
| out_ready | input | 1 | Downstream takes the outgoing packet |
| ack_valid | input | 1 | Acknowledgement present this cycle |
| ack_nak | input | 1 | 1 = negative, 0 = positive acknowledgement |
| ack_seq | input | 12 | Sequence number named by the acknowledgement |

## Verification
The hardest case to reach is a positive acknowledgement that lands in the middle of a retransmission and overtakes the resend pointer. Getting there needs a negative acknowledgement, one accepted resend beat, then a stalled output while the acknowledgement is applied. The bench lines up that cycle directly, and it also drives the timer to expiry with the far end silent. A long constrained-random run then mixes bursts, partial and full acknowledgements, negative acknowledgements at random offsets and stale values until the counter has wrapped past 4095.

// File: rtl/dllr_pkg.sv
package dllr_pkg;

  localparam int SEQ_W = 12;

  typedef enum logic {
    MODE_SEND   = 1'b0,
    MODE_REPLAY = 1'b1
  } dllr_mode_e;

  // forward distance from b to a in the wrapping sequence space
  function automatic logic [SEQ_W-1:0] seq_dist(input logic [SEQ_W-1:0] a,
                                                input logic [SEQ_W-1:0] b);
    return a - b;
  endfunction

endpackage

// File: rtl/dllr_seq_track.sv
module dllr_seq_track
  import dllr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             ack_valid_i,
  input  logic             ack_nak_i,
  input  logic [SEQ_W-1:0] ack_seq_i,
  output logic [SEQ_W-1:0] base_seq_o,
  output logic [SEQ_W-1:0] next_seq_o,
  output logic [CW-1:0]    cnt_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             nak_hit_o,
  output logic             progress_o,
  output logic [CW-1:0]    rel_o
);

  logic [SEQ_W-1:0] base_q, base_d;
  logic [SEQ_W-1:0] next_q, next_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SEQ_W-1:0] off;
  logic             hit;
  logic [CW-1:0]    rel;

  // an acknowledgement counts only when it names a held packet
  assign off = seq_dist(ack_seq_i, base_q);
  assign hit = ack_valid_i && (off < SEQ_W'(cnt_q));

  always_comb begin
    rel = '0;
    if (hit) begin
      if (ack_nak_i) rel = CW'(off);
      else           rel = CW'(off) + CW'(1);
    end
  end

  always_comb begin
    next_d = next_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    if (push_i) next_d = next_q + SEQ_W'(1);
    cnt_d  = cnt_q + CW'(push_i) - rel;
    base_d = base_q + SEQ_W'(rel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      next_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      next_q <= next_d;
      cnt_q  <= cnt_d;
    end
  end

  assign base_seq_o = base_q;
  assign next_seq_o = next_q;
  assign cnt_o      = cnt_q;
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign nak_hit_o  = hit && ack_nak_i;
  assign progress_o = hit && (rel != '0);
  assign rel_o      = rel;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_dist(next_q, base_q) == SEQ_W'(cnt_q));

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ack_nak_i) |=> (base_q == SEQ_W'($past(ack_seq_i) + SEQ_W'(1))));

  assert_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_i && !hit && !push_i) |=> $stable(cnt_q) && $stable(base_q));

endmodule

// File: rtl/dllr_replay_buf.sv
module dllr_replay_buf
  import dllr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [SEQ_W-1:0]  wseq_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEQ_W-1:0]  rseq_i,
  output logic [DATA_W-1:0] rdata_o
);

  // slot = low bits of the sequence number; DEPTH divides 4096
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wseq_i[AW-1:0]] <= wdata_i;
  end

  assign rdata_o = mem[rseq_i[AW-1:0]];

  initial begin
    assert_depth_pow2_R3: assert ((DEPTH & (DEPTH - 1)) == 0 && DEPTH <= 2048);
  end

endmodule

// File: rtl/dllr_replay_timer.sv
module dllr_replay_timer #(
  parameter int TIMEOUT = 256,
  localparam int TW     = $clog2(TIMEOUT) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic expire_o
);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          at_end;

  assign at_end   = (tmr_q == TW'(TIMEOUT - 1));
  assign expire_o = run_i && !clear_i && at_end;

  always_comb begin
    tmr_d = tmr_q;
    if (clear_i)     tmr_d = '0;
    else if (run_i)  tmr_d = at_end ? '0 : tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q < TW'(TIMEOUT));

  assert_timer_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (tmr_q == '0));

endmodule

// File: rtl/dllr_replay_ctrl.sv
module dllr_replay_ctrl
  import dllr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 256,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [SEQ_W-1:0]  out_seq,
  input  logic              out_ready,
  input  logic              ack_valid,
  input  logic              ack_nak,
  input  logic [SEQ_W-1:0]  ack_seq
);

  dllr_mode_e       mode_q, mode_d;
  logic [SEQ_W-1:0] rp_q, rp_d;
  logic [SEQ_W-1:0] rp_adv;

  logic [SEQ_W-1:0] base_seq, next_seq;
  logic [CW-1:0]    cnt, rel;
  logic             full, empty, nak_hit, progress;
  logic             push, fire, expire;
  logic [DATA_W-1:0] rd_data;

  dllr_seq_track #(.DEPTH(DEPTH)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .ack_valid_i(ack_valid),
    .ack_nak_i  (ack_nak),
    .ack_seq_i  (ack_seq),
    .base_seq_o (base_seq),
    .next_seq_o (next_seq),
    .cnt_o      (cnt),
    .full_o     (full),
    .empty_o    (empty),
    .nak_hit_o  (nak_hit),
    .progress_o (progress),
    .rel_o      (rel)
  );

  dllr_replay_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk    (clk),
    .we_i   (push),
    .wseq_i (next_seq),
    .wdata_i(in_data),
    .rseq_i (rp_q),
    .rdata_o(rd_data)
  );

  dllr_replay_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (!empty && (mode_q == MODE_SEND)),
    .clear_i (progress || nak_hit || empty),
    .expire_o(expire)
  );

  // output steering: fresh traffic or stored copies
  always_comb begin
    if (mode_q == MODE_REPLAY) begin
      out_valid = 1'b1;
      out_data  = rd_data;
      out_seq   = rp_q;
      in_ready  = 1'b0;
    end else begin
      out_valid = in_valid && !full;
      out_data  = in_data;
      out_seq   = next_seq;
      in_ready  = out_ready && !full;
    end
  end

  assign fire = out_valid && out_ready;
  assign push = (mode_q == MODE_SEND) && in_valid && in_ready;

  // resend pointer: advance on each beat, jump past released entries
  always_comb begin
    mode_d = mode_q;
    rp_d   = rp_q;
    rp_adv = fire ? rp_q + SEQ_W'(1) : rp_q;
    if (nak_hit) begin
      mode_d = MODE_REPLAY;
      rp_d   = ack_seq;
    end else if (expire) begin
      mode_d = MODE_REPLAY;
      rp_d   = base_seq;
    end else if (mode_q == MODE_REPLAY) begin
      if (seq_dist(rp_adv, base_seq) < SEQ_W'(rel))
        rp_adv = base_seq + SEQ_W'(rel);
      rp_d = rp_adv;
      if (rp_adv == next_seq) mode_d = MODE_SEND;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SEND;
      rp_q   <= '0;
    end else begin
      mode_q <= mode_d;
      rp_q   <= rp_d;
    end
  end

  assert_replay_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_REPLAY) |-> (seq_dist(rp_q, base_seq) < SEQ_W'(cnt)));

  assert_nak_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nak_hit |=> (mode_q == MODE_REPLAY) && (rp_q == $past(ack_seq)));

  assert_no_new_in_replay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_REPLAY) && ($past(mode_q) == MODE_REPLAY)) |-> $stable(next_seq));

  assert_timeout_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !nak_hit) |=> (mode_q == MODE_REPLAY) && (rp_q == $past(base_seq)));

endmodule

// File: tb/tb_dllr_replay_ctrl.sv
module tb_dllr_replay_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int TO = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, out_valid, in_ready, out_ready;
  logic [DW-1:0] in_data, out_data;
  logic [11:0]   out_seq, ack_seq;
  logic          ack_valid, ack_nak;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int m_base = 0, m_next = 0, m_cnt = 0, sent = 0;
  bit wrapped = 0;
  logic [DW-1:0] mdata [DEPTH];

  dllr_replay_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_seq(out_seq), .out_ready(out_ready),
    .ack_valid(ack_valid), .ack_nak(ack_nak), .ack_seq(ack_seq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung (act %0d cycles, exp < 150000)", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %0d exp %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int wrap(input int v);
    return v & 4095;
  endfunction

  task automatic send(input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; out_ready = 1'b1;
    #1;
    chk(in_ready && out_valid, "R3 accept", {in_ready, out_valid}, 3);
    chk(out_seq == m_next[11:0], "R2 seq", out_seq, m_next);
    chk(out_data == d, "R2 data", out_data, d);
    if (out_seq == 12'd0 && sent > 0) wrapped = 1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    mdata[m_next % DEPTH] = d;
    m_next = wrap(m_next + 1);
    m_cnt++; sent++;
  endtask

  task automatic ackn(input bit nak, input int s);
    int off, rel;
    @(negedge clk);
    ack_valid = 1'b1; ack_nak = nak; ack_seq = s[11:0];
    @(posedge clk);
    #1 ack_valid = 1'b0;
    off = wrap(s - m_base);
    if (off < m_cnt) begin
      rel = nak ? off : off + 1;
      m_base = wrap(m_base + rel);
      m_cnt -= rel;
    end
  endtask

  // resend beats at consecutive cycles, with a new packet offered to test R7
  task automatic expect_replay(input int from, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      out_ready = 1'b1; in_valid = 1'b1; in_data = 32'hDEAD_0000 + i;
      #1;
      chk(out_valid, tag, out_valid, 1);
      chk(out_seq == wrap(from + i), tag, out_seq, wrap(from + i));
      chk(out_data == mdata[wrap(from + i) % DEPTH], tag, out_data, mdata[wrap(from + i) % DEPTH]);
      chk(!in_ready, "R7 held off", in_ready, 0);
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
    @(negedge clk);
    #1;
    chk(!out_valid, {tag, " end"}, out_valid, 0);
    if (m_cnt < DEPTH) chk(in_ready, {tag, " resume"}, in_ready, 1);
  endtask

  task automatic ack_all();
    if (m_cnt > 0) ackn(1'b0, wrap(m_next - 1));
  endtask

  initial begin
    int cnt_to, b, n, r, off;
    bit quiet;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; in_valid = 0; in_data = '0; out_ready = 1'b1;
    ack_valid = 0; ack_nak = 0; ack_seq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    @(negedge clk); #1;
    chk(!out_valid, "R1 idle out", out_valid, 0);
    chk(in_ready, "R1 ready", in_ready, 1);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 32'h1111;
    #1;
    chk(out_valid && out_seq == 0, "R1 first seq", out_seq, 0);
    @(negedge clk) in_valid = 1'b0; out_ready = 1'b1;

    // R3: fill the store
    for (int i = 0; i < DEPTH; i++) send(32'hA000 + i);
    @(negedge clk);
    in_valid = 1'b1; #1;
    chk(!in_ready, "R3 full ready", in_ready, 0);
    chk(!out_valid, "R3 full valid", out_valid, 0);
    @(negedge clk) in_valid = 1'b0;
    // R4: one release frees one slot
    ackn(1'b0, m_base);
    chk(m_cnt == DEPTH - 1, "R4 model", m_cnt, DEPTH - 1);
    send(32'hB000);
    ack_all();

    // R4: partial release, then a NAK shows released ones are gone
    for (int i = 0; i < 5; i++) send(32'hC000 + i);
    ackn(1'b0, wrap(m_base + 1));
    b = m_base;
    ackn(1'b1, b);
    expect_replay(b, 3, "R4 released skipped");
    ack_all();

    // R5: stale and out-of-window acknowledgements
    for (int i = 0; i < 3; i++) send(32'hD000 + i);
    b = m_base;
    ackn(1'b0, wrap(b - 1));
    ackn(1'b0, wrap(b + 5));
    ackn(1'b1, wrap(b + 7));
    @(negedge clk); #1;
    chk(!out_valid, "R5 no replay", out_valid, 0);
    ackn(1'b1, b);
    expect_replay(b, 3, "R5 nothing released");
    ack_all();

    // R6: NAK in the middle
    for (int i = 0; i < 5; i++) send(32'hE000 + i);
    b = wrap(m_base + 2);
    ackn(1'b1, b);
    chk(m_base == b, "R6 older released", m_base, b);
    expect_replay(b, 3, "R6 resend");
    ack_all();

    // R10: ACK overtakes the resend pointer
    for (int i = 0; i < 4; i++) send(32'hF000 + i);
    b = m_base;
    ackn(1'b1, b);
    @(negedge clk); out_ready = 1'b1; #1;
    chk(out_seq == b[11:0], "R10 beat0", out_seq, b);
    @(negedge clk);
    out_ready = 1'b0; ack_valid = 1'b1; ack_nak = 1'b0; ack_seq = wrap(b + 2);
    #1;
    chk(out_valid && out_seq == wrap(b + 1), "R10 stalled beat", out_seq, wrap(b + 1));
    @(posedge clk);
    #1 ack_valid = 1'b0;
    m_base = wrap(b + 3); m_cnt = 1;
    @(negedge clk); out_ready = 1'b1; #1;
    chk(out_valid && out_seq == wrap(b + 3), "R10 skip", out_seq, wrap(b + 3));
    chk(out_data == mdata[wrap(b + 3) % DEPTH], "R10 data", out_data, mdata[wrap(b + 3) % DEPTH]);
    @(negedge clk); #1;
    chk(!out_valid, "R10 ended", out_valid, 0);
    ack_all();

    // R8: silent far end
    for (int i = 0; i < 3; i++) send(32'h7700 + i);
    b = m_base;
    cnt_to = 0;
    for (int k = 0; k < TO + 20; k++) begin
      @(negedge clk); #1;
      if (out_valid) break;
      cnt_to++;
    end
    chk(cnt_to >= TO - 3 && cnt_to <= TO - 1, "R8 timeout delay", cnt_to, TO - 2);
    chk(out_seq == b[11:0], "R8 oldest first", out_seq, b);
    chk(out_data == mdata[b % DEPTH], "R8 data", out_data, mdata[b % DEPTH]);
    @(posedge clk);
    expect_replay(wrap(b + 1), 2, "R8 resend");
    ack_all();

    // R9: empty store never times out
    quiet = 1;
    for (int k = 0; k < TO + 10; k++) begin
      @(negedge clk); #1;
      if (out_valid) quiet = 0;
    end
    chk(quiet, "R9 empty stopped", !quiet, 0);
    // R9: progress restarts the count
    send(32'h9900); send(32'h9901);
    repeat (TO - 10) @(negedge clk);
    ackn(1'b0, m_base);
    quiet = 1;
    for (int k = 0; k < TO - 10; k++) begin
      @(negedge clk); #1;
      if (out_valid) quiet = 0;
    end
    chk(quiet, "R9 restart", !quiet, 0);
    ack_all();

    // random mix until the counter wraps (R2, R4, R5, R6)
    for (int it = 0; it < 4000 && sent < 4300; it++) begin
      n = 1 + ($urandom % 4);
      if (n > DEPTH - m_cnt) n = DEPTH - m_cnt;
      for (int i = 0; i < n; i++) send($urandom);
      r = $urandom % 4;
      if (m_cnt == 0) r = 2;
      case (r)
        0: begin off = $urandom % m_cnt; ackn(1'b0, wrap(m_base + off)); end
        1: begin
             off = $urandom % m_cnt;
             b = wrap(m_base + off);
             ackn(1'b1, b);
             expect_replay(b, m_cnt, "R6 random");
           end
        2: ack_all();
        default: begin
             ackn($urandom % 2, wrap(m_base - 1 - ($urandom % 100)));
             ack_all();
           end
      endcase
    end
    chk(wrapped, "R2 wrap 4095->0", wrapped, 1);
    ack_all();
    @(negedge clk); #1;
    chk(!out_valid && in_ready, "R4 drained", {out_valid, in_ready}, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule